// File: doc/BRIEF.md
# Write-once synchronizing heap memory

This block is one bank of heap storage shared by processing elements that talk to memory through split-phase messages. Every request carries an opaque reply tag: the requester's continuation and a frame offset, packed into one field. A reply is a START message that carries a data word together with that tag, so the requester can resume the right thread. Ordinary reads and writes behave like a plain memory.

Two further operations add producer/consumer synchronization on single words. Each word has a presence state, which is either empty or full. A synchronizing read of an empty word is answered later, not at once: its tag is parked on a list belonging to that word. When the one synchronizing write for that word arrives, the block stores the value, marks the word full, and answers every parked reader with the new value. A consumer may therefore issue its read before the producer has written.

Parked tags are held in a shared pool of list nodes. The nodes are returned to the pool while the list is answered. Requests enter on a valid/ready port and START replies leave on a registered valid/ready port.

Top module: `istruct_heap`

## Requirements
- R1: A plain read (req_op = 0) that is accepted on an edge makes rsp_valid high after that same edge. The reply carries the word last stored at the address and the request's tag.
- R2: A plain write (req_op = 1) stores req_data at the address and produces no reply. It leaves the presence state and any parked readers of that word unchanged.
- R3: While rst is high, every word becomes empty and every parked list is dropped. After rst goes low, rsp_valid and err_flag are 0 and req_ready is 1.
- R4: A synchronizing read (req_op = 2) of a full word is answered exactly like a plain read.
- R5: A synchronizing read of an empty word produces no reply. Its tag is parked on that word's list.
- R6: A synchronizing write (req_op = 3) to an empty word stores the value and marks the word full. Parked readers, if any, each get one START carrying the written value and their own tag, most recently parked first, one per cycle while rsp_ready stays high. The first of these STARTs becomes valid one edge later than a plain read's reply would.
- R7: req_ready is high only when three conditions hold: no parked list is being answered, the output register is empty or is being taken in that cycle, and R9 does not apply. req_ready stays low until the last START of a list has been loaded.
- R8: A synchronizing write to a full word leaves the stored value unchanged and sets err_flag. err_flag then stays high until reset.
- R9: When all NODES list nodes hold parked tags, a synchronizing read of an empty word is not accepted. Requests of every other kind are still accepted.
- R10: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_data and rsp_tag hold their values.
- R11: The nodes of an answered list return to the pool, so NODES new readers can be parked once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request is taken on this edge |
| req_op | input | 2 | 0 plain read, 1 plain write, 2 synchronizing read, 3 synchronizing write |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Write value |
| req_tag | input | TAG_W | Reply tag (continuation and offset) |
| rsp_valid | output | 1 | A START reply is presented |
| rsp_ready | input | 1 | The reply is taken on this edge |
| rsp_data | output | DATA_W | Value carried by the START |
| rsp_tag | output | TAG_W | Tag of the reader being answered |
| err_flag | output | 1 | Sticky flag for a second synchronizing write to a word |

## Verification
Some properties are checked by assertions on every cycle:
- a reply follows each accepted read on the next edge, and none follows a plain write or a parked read;
- the input is closed while a list is being answered or the node pool is full;
- the output stays steady under backpressure;
- the error flag never falls.

Other behaviour can only be shown by the bench's scenarios against its own model. This covers the values carried in replies, which readers a write answers and in what order, presence surviving plain writes, clearing on reset, and reuse of the node pool after exhaustion.

// File: rtl/ih_pkg.sv
package ih_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_IREAD  = 2'd2,
    OP_IWRITE = 2'd3
  } ih_op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } ih_state_e;
endpackage

// File: rtl/ih_node_pool.sv
// Free bitmap of parked-reader list nodes; hands out the lowest free index.
module ih_node_pool #(
  parameter int NODES = 8,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic              free_en,
  input  logic [NODE_W-1:0] free_idx,
  output logic [NODE_W-1:0] alloc_idx,
  output logic              empty
);
  logic [NODES-1:0] free_q;

  always_comb begin
    alloc_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_idx = NODE_W'(i);
    end
  end

  assign empty = (free_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
    end else begin
      if (alloc_en) free_q[alloc_idx] <= 1'b0;
      if (free_en)  free_q[free_idx]  <= 1'b1;
    end
  end
endmodule

// File: rtl/ih_node_store.sv
// Storage for parked reader tags and list links (distributed RAM style).
module ih_node_store #(
  parameter int NODES = 8,
  parameter int TAG_W = 16,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [NODE_W-1:0] widx,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [NODE_W-1:0] wnext,
  input  logic              wlast,
  input  logic [NODE_W-1:0] ridx,
  output logic [TAG_W-1:0]  rtag,
  output logic [NODE_W-1:0] rnext,
  output logic              rlast
);
  logic [TAG_W-1:0]  tag_mem  [NODES];
  logic [NODE_W-1:0] next_mem [NODES];
  logic              last_mem [NODES];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx]  <= wtag;
      next_mem[widx] <= wnext;
      last_mem[widx] <= wlast;
    end
  end

  assign rtag  = tag_mem[ridx];
  assign rnext = next_mem[ridx];
  assign rlast = last_mem[ridx];
endmodule

// File: rtl/ih_word_store.sv
// Data words; one write port, one asynchronous read port.
module ih_word_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/istruct_heap.sv
module istruct_heap import ih_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 16,
  parameter int NODES  = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              err_flag
);
  ih_state_e         state_q;
  logic [NODE_W-1:0] cur_q;
  logic [DATA_W-1:0] val_q;
  logic [DEPTH-1:0]  full_q;
  logic [DEPTH-1:0]  list_q;
  logic [NODE_W-1:0] head_q [DEPTH];
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [TAG_W-1:0]  rsp_tag_q;
  logic              err_q;

  ih_op_e            op;
  logic              tgt_full, slot_free, park_block, accept, drain_w, drain_go;
  logic              word_we, alloc_en, pool_empty;
  logic [NODE_W-1:0] alloc_idx;
  logic [DATA_W-1:0] word_rdata;
  logic [TAG_W-1:0]  node_tag;
  logic [NODE_W-1:0] node_next;
  logic              node_last;

  assign op         = ih_op_e'(req_op);
  assign tgt_full   = full_q[req_addr];
  assign slot_free  = !rsp_valid_q || rsp_ready;
  assign drain_w    = (state_q == ST_DRAIN);
  assign park_block = (op == OP_IREAD) && !tgt_full && pool_empty;
  assign req_ready  = !drain_w && slot_free && !park_block;
  assign accept     = req_valid && req_ready;
  assign drain_go   = drain_w && slot_free;
  assign word_we    = accept && ((op == OP_WRITE) || ((op == OP_IWRITE) && !tgt_full));
  assign alloc_en   = accept && (op == OP_IREAD) && !tgt_full;

  ih_word_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_words (
    .clk(clk), .we(word_we), .addr(req_addr), .wdata(req_data), .rdata(word_rdata)
  );

  ih_node_pool #(.NODES(NODES)) u_pool (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .free_en(drain_go),
    .free_idx(cur_q), .alloc_idx(alloc_idx), .empty(pool_empty)
  );

  ih_node_store #(.NODES(NODES), .TAG_W(TAG_W)) u_nodes (
    .clk(clk), .we(alloc_en), .widx(alloc_idx), .wtag(req_tag),
    .wnext(head_q[req_addr]), .wlast(!list_q[req_addr]),
    .ridx(cur_q), .rtag(node_tag), .rnext(node_next), .rlast(node_last)
  );

  // List heads carry no reset; list_q says whether a head is meaningful.
  always_ff @(posedge clk) begin
    if (alloc_en) head_q[req_addr] <= alloc_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      full_q      <= '0;
      list_q      <= '0;
      rsp_valid_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (rsp_ready) rsp_valid_q <= 1'b0;
      if (accept) begin
        case (op)
          OP_READ: begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= word_rdata;
            rsp_tag_q   <= req_tag;
          end
          OP_IREAD: begin
            if (tgt_full) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= word_rdata;
              rsp_tag_q   <= req_tag;
            end else begin
              list_q[req_addr] <= 1'b1;
            end
          end
          OP_IWRITE: begin
            if (tgt_full) begin
              err_q <= 1'b1;
            end else begin
              full_q[req_addr] <= 1'b1;
              if (list_q[req_addr]) begin
                list_q[req_addr] <= 1'b0;
                state_q <= ST_DRAIN;
                cur_q   <= head_q[req_addr];
                val_q   <= req_data;
              end
            end
          end
          default: ;
        endcase
      end
      if (drain_go) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= val_q;
        rsp_tag_q   <= node_tag;
        if (node_last) state_q <= ST_IDLE;
        else           cur_q   <= node_next;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_tag   = rsp_tag_q;
  assign err_flag  = err_q;
endmodule

// File: rtl/ih_heap_chk.sv
module ih_heap_chk #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [TAG_W-1:0]  req_tag,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic              err_flag,
  input logic              draining,
  input logic              pool_empty,
  input logic              tgt_full
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_read_reply_r1: assert property (@(posedge clk) disable iff (rst)
    acc && req_op == 2'd0 |=> rsp_valid && rsp_tag == $past(req_tag));

  p_write_silent_r2: assert property (@(posedge clk) disable iff (rst)
    acc && req_op == 2'd1 |=> !rsp_valid);

  p_iread_full_r4: assert property (@(posedge clk) disable iff (rst)
    acc && req_op == 2'd2 && tgt_full |=> rsp_valid && rsp_tag == $past(req_tag));

  p_park_silent_r5: assert property (@(posedge clk) disable iff (rst)
    acc && req_op == 2'd2 && !tgt_full |=> !rsp_valid);

  p_drain_closed_r7: assert property (@(posedge clk) disable iff (rst)
    draining |-> !req_ready);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  p_pool_hold_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 2'd2 && !tgt_full && pool_empty |-> !req_ready);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_tag));
endmodule

bind istruct_heap ih_heap_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_tag(rsp_tag), .err_flag(err_flag),
  .draining(drain_w), .pool_empty(pool_empty), .tgt_full(tgt_full)
);

// File: tb/tb_istruct_heap.sv
`timescale 1ns/1ps
module tb_istruct_heap;
  localparam int NODES = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [3:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic [15:0] req_tag = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [15:0] rsp_tag;
  logic        err_flag;

  always #2.5 clk = ~clk;

  istruct_heap dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_tag(rsp_tag), .err_flag(err_flag)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // Bench model
  logic [15:0] m_mem   [16];
  bit          m_known [16];
  bit          m_full  [16];
  logic [15:0] m_park  [16][NODES];
  int          m_pn    [16];
  int          m_parked;
  bit          m_err;
  bit          m_lag;
  logic [15:0] q_data [$];
  bit          q_known [$];
  logic [15:0] q_tag [$];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit exp_ready(input bit draining, input bit rv, input bit rr,
                                   input logic [1:0] op, input logic [3:0] a);
    bit block;
    block = (op == 2'd2) && !m_full[a] && (m_parked == NODES);
    return !draining && (!rv || rr) && !block;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin
      m_full[i] = 1'b0;
      m_pn[i] = 0;
    end
    m_parked = 0;
    m_err = 1'b0;
    m_lag = 1'b0;
    q_data.delete(); q_known.delete(); q_tag.delete();
  endtask

  task automatic push_rsp(input logic [15:0] d, input bit k, input logic [15:0] t);
    q_data.push_back(d); q_known.push_back(k); q_tag.push_back(t);
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic [3:0] a,
                      input logic [15:0] d, input logic [15:0] t, input bit rr);
    bit rv, draining, er, block;
    string rl;
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_data = d; req_tag = t;
    rsp_ready = rr;
    #1;
    rv = (q_data.size() > 0) && !m_lag;
    chk(cur_req, {31'd0, rsp_valid}, {31'd0, rv});
    draining = q_data.size() > (rv ? 1 : 0);
    block = (op == 2'd2) && !m_full[a] && (m_parked == NODES);
    er = exp_ready(draining, rv, rr, op, a);
    rl = draining ? "R7" : (block ? "R9" : cur_req);
    chk(rl, {31'd0, req_ready}, {31'd0, er});
    chk("R8", {31'd0, err_flag}, {31'd0, m_err});
    if (rv && rsp_valid) begin
      if (q_known[0]) chk(cur_req, {16'd0, rsp_data}, {16'd0, q_data[0]});
      chk(cur_req, {16'd0, rsp_tag}, {16'd0, q_tag[0]});
    end
    if (rv && rr) begin
      void'(q_data.pop_front()); void'(q_known.pop_front()); void'(q_tag.pop_front());
    end
    m_lag = 1'b0;
    if (v && er) begin
      case (op)
        2'd0: push_rsp(m_mem[a], m_known[a], t);
        2'd1: begin m_mem[a] = d; m_known[a] = 1'b1; end
        2'd2: begin
          if (m_full[a]) push_rsp(m_mem[a], m_known[a], t);
          else begin
            m_park[a][m_pn[a]] = t;
            m_pn[a]++;
            m_parked++;
          end
        end
        default: begin
          if (m_full[a]) m_err = 1'b1;
          else begin
            m_mem[a] = d; m_known[a] = 1'b1; m_full[a] = 1'b1;
            if (m_pn[a] > 0) begin
              for (int i = m_pn[a] - 1; i >= 0; i--) push_rsp(d, 1'b1, m_park[a][i]);
              m_parked -= m_pn[a];
              m_pn[a] = 0;
              m_lag = 1'b1;
            end
          end
        end
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    #1;
    chk("R3", {31'd0, rsp_valid}, 32'd0);
    chk("R3", {31'd0, err_flag}, 32'd0);
    chk("R3", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic idle(input int n, input bit rr);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 4'd0, 16'd0, 16'd0, rr);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_mem[i] = '0; m_known[i] = 1'b0; end
    model_clear();
    void'($urandom(32'd20240611));
    do_reset();

    // R1, R4, R8: write-once word, plain and synchronizing reads, double write
    cur_req = "R1";
    step(1, 2'd3, 4'd1, 16'h1111, 16'h0a01, 1);
    step(1, 2'd0, 4'd1, 16'h0, 16'h0a02, 1);
    cur_req = "R4";
    step(1, 2'd2, 4'd1, 16'h0, 16'h0a03, 1);
    cur_req = "R8";
    step(1, 2'd3, 4'd1, 16'h2222, 16'h0a04, 1);
    step(1, 2'd0, 4'd1, 16'h0, 16'h0a05, 1);
    idle(2, 1);

    // R2, R5: plain write keeps the word empty, readers park silently
    cur_req = "R2";
    step(1, 2'd1, 4'd2, 16'h3333, 16'h0b00, 1);
    cur_req = "R5";
    step(1, 2'd2, 4'd2, 16'h0, 16'h0b01, 1);
    step(1, 2'd2, 4'd2, 16'h0, 16'h0b02, 1);
    step(1, 2'd2, 4'd2, 16'h0, 16'h0b03, 1);
    idle(3, 1);
    // R6, R7: the write answers all three newest first; input closed meanwhile
    cur_req = "R6";
    step(1, 2'd3, 4'd2, 16'h4444, 16'h0b04, 1);
    for (int i = 0; i < 5; i++) step(1, 2'd0, 4'd1, 16'h0, 16'h0b10, 1);
    idle(2, 1);

    // R9: fill the node pool, the next parking read is held
    cur_req = "R9";
    for (int i = 0; i < NODES; i++) step(1, 2'd2, 4'd3, 16'h0, 16'h0c00 + 16'(i), 1);
    step(1, 2'd2, 4'd4, 16'h0, 16'h0c20, 1);
    step(1, 2'd2, 4'd4, 16'h0, 16'h0c21, 1);
    step(1, 2'd1, 4'd5, 16'h5555, 16'h0c22, 1);
    // R10: answer the list under backpressure
    cur_req = "R10";
    step(1, 2'd3, 4'd3, 16'h6666, 16'h0c30, 1);
    for (int i = 0; i < 24; i++) step(1, 2'd0, 4'd5, 16'h0, 16'h0c40, i[1]);
    idle(2, 1);
    // R11: pool refilled, NODES readers can park again
    cur_req = "R11";
    for (int i = 0; i < NODES; i++) step(1, 2'd2, 4'd6, 16'h0, 16'h0d00 + 16'(i), 1);
    step(1, 2'd3, 4'd6, 16'h7777, 16'h0d20, 1);
    idle(NODES + 2, 1);

    // R3: reset empties words and drops lists
    cur_req = "R3";
    step(1, 2'd2, 4'd7, 16'h0, 16'h0e00, 1);
    do_reset();
    step(1, 2'd2, 4'd1, 16'h0, 16'h0e01, 1);
    step(1, 2'd3, 4'd7, 16'h8888, 16'h0e02, 1);
    idle(3, 1);
    step(1, 2'd3, 4'd1, 16'h9999, 16'h0e03, 1);
    idle(3, 1);

    // Random epochs, each on its own small set of words
    cur_req = "R1";
    for (int e = 0; e < 20; e++) begin
      do_reset();
      cur_req = "R6";
      for (int s = 0; s < 400; s++) begin
        step($urandom % 4 != 0, 2'($urandom % 4), 4'((e % 4) * 4 + $urandom % 4),
             16'($urandom), 16'($urandom), $urandom % 4 != 0);
      end
      idle(NODES + 4, 1);
    end
    summary();
  end
endmodule